// File: doc/BRIEF.md
# Four-Way Set-Associative Translation Buffer with Paired Recency Replacement

This block caches page translations in a set-associative array. The number of sets is a parameter, and each set holds four ways. Each way carries four fields: a page tag, a two-bit region-type flag, a two-bit recency value and a payload word. The payload is opaque, so the block never interprets it.

A lookup presents a virtual address. One cycle later the block reports whether the page is present, which way matched, and the flags and payload of that way. A refill presents a page address with its flags and payload. The block picks a victim way in the addressed set, writes the entry there and reports the chosen way one cycle later.

Replacement groups the ways into two pairs, {0,1} and {2,3}. A touched way becomes the most recent member of its pair, and the other pair loses its upper recency bit. A global invalidate empties the whole array in one cycle. The page walker that produces refills sits outside this block.

Top module: `tlb4way_hlru`

## Requirements
- R1: After reset every way of every set is invalid (tag all ones, flags, recency and payload zero), so the first lookup to any page reports a miss, and respValid and fillValid are low during reset.
- R2: Pages are 4 KiB. The stored tag is the address with bits 11:0 cleared, and the set index is address bits [12 +: log2(NUM_SETS)]. Two addresses on the same page but with different offsets therefore hit the same entry.
- R3: A lookup request produces respValid exactly one cycle later. On a miss, respHit, respWay, respFlags and respPayload are all zero.
- R4: On a lookup, the ways of the addressed set are compared in order 0 to 3. The first way whose tag equals the lookup tag is reported as respWay, together with its flags and payload.
- R5: Touching way 0 sets recency(0)=3 and recency(1)=2. Touching way 1 sets recency(0)=2 and recency(1)=3. In both cases ways 2 and 3 keep only bit 0. Touching way 2 or 3 works the same way on the pair {2,3}, and ways 0 and 1 keep only bit 0. A lookup hit and a refill each touch the way they select.
- R6: A refill writes the first invalid way of the set, searched in order 0 to 3.
- R7: When all four ways are valid, a refill writes the first way among 0, 1 and 2 whose recency is 0. If none of them is 0, the refill writes way 3.
- R8: invalidateAll empties every set in that cycle. It also overrides any refill in the same cycle, so no write takes place and fillValid stays low. A lookup in that cycle reports a miss.
- R9: A lookup and a refill in the same cycle are handled as refill first, then lookup. The lookup sees the freshly written entry and the recency left by the refill, and then applies its own touch on a hit.
- R10: A refill produces fillValid one cycle later, with fillWay giving the way that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupAddr | input | 32 | Virtual address to translate |
| refillValid | input | 1 | Refill request strobe |
| refillAddr | input | 32 | Page address of the new entry |
| refillFlags | input | 2 | Region-type flags of the new entry |
| refillPayload | input | 32 | Payload word of the new entry |
| invalidateAll | input | 1 | Empty the whole array |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respWay | output | 2 | Way that hit |
| respFlags | output | 2 | Flags of the hit way |
| respPayload | output | 32 | Payload of the hit way |
| fillValid | output | 1 | Refill accepted |
| fillWay | output | 2 | Way written by the refill |

## Verification
The assertions assume that every input is driven to a known value in every cycle after reset. They also assume that refill addresses carry a tag with zero low bits, which holds for any address because the block clears those bits itself. They place no restriction on how lookups, refills and invalidates combine.

The stimulus is built to exercise as many combinations as possible. It drives all three request kinds in independent mixes, and it aims them at only a few sets and a small pool of tags. This produces frequent same-set collisions, duplicate refills, full sets and recency-driven evictions.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int WAYS      = 4;
  localparam int WAY_W     = 2;
  localparam int REC_W     = 2;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int FLAG_W    = 2;
  localparam int PAY_W     = 32;

  localparam logic [ADDR_W-1:0] INVALID_TAG = '1;

  typedef logic [WAYS*REC_W-1:0] recVec_t;

  typedef struct packed {
    logic [ADDR_W-1:0] tag;
    logic [FLAG_W-1:0] flags;
    logic [PAY_W-1:0]  payload;
  } wayEntry_t;

  typedef wayEntry_t [WAYS-1:0] setView_t;

  localparam wayEntry_t EMPTY_WAY = '{tag: INVALID_TAG, flags: '0, payload: '0};

  typedef struct packed {
    logic              invAll;
    logic              fillWe;
    logic [WAY_W-1:0]  fillWay;
    recVec_t           fillRec;
    logic              lookRecWe;
    recVec_t           lookRec;
    logic              respLoad;
    logic              respHit;
    logic [WAY_W-1:0]  respWay;
    logic [FLAG_W-1:0] respFlags;
    logic [PAY_W-1:0]  respPayload;
  } ctrlStrobe_t;

  // Recency update applied to the way that was selected.
  function automatic recVec_t touchWay(recVec_t r, logic [WAY_W-1:0] w);
    recVec_t n;
    n = r;
    case (w)
      2'd0: begin n[1:0] = 2'd3; n[3:2] = 2'd2; n[5] = 1'b0; n[7] = 1'b0; end
      2'd1: begin n[1:0] = 2'd2; n[3:2] = 2'd3; n[5] = 1'b0; n[7] = 1'b0; end
      2'd2: begin n[5:4] = 2'd3; n[7:6] = 2'd2; n[1] = 1'b0; n[3] = 1'b0; end
      default: begin n[5:4] = 2'd2; n[7:6] = 2'd3; n[1] = 1'b0; n[3] = 1'b0; end
    endcase
    return n;
  endfunction

  // Victim: first invalid way, else first zero-recency way of 0..2, else way 3.
  function automatic logic [WAY_W-1:0] pickVictim(setView_t s, recVec_t r);
    logic [WAY_W-1:0] v;
    logic found;
    v = WAY_W'(WAYS-1);
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && s[i].tag == INVALID_TAG) begin
        v = WAY_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < WAYS-1; i++) begin
      if (!found && r[i*REC_W +: REC_W] == '0) begin
        v = WAY_W'(i);
        found = 1'b1;
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/tlb_hlru_ctrl.sv
module tlb_hlru_ctrl
  import tlbPkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic                refillValid,
  input  logic [ADDR_W-1:0]   refillAddr,
  input  logic [FLAG_W-1:0]   refillFlags,
  input  logic [PAY_W-1:0]    refillPayload,
  input  logic                invalidateAll,
  input  setView_t            fillView,
  input  recVec_t             fillRecCur,
  input  setView_t            lookView,
  input  recVec_t             lookRecCur,
  output logic [SET_W-1:0]    fillSet,
  output logic [SET_W-1:0]    lookSet,
  output wayEntry_t           fillEntry,
  output ctrlStrobe_t         strb
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'((1 << PAGE_BITS) - 1);

  logic [ADDR_W-1:0] lookTag;
  logic [WAY_W-1:0]  victim;
  recVec_t           fillRecNew;
  logic              sameSet;
  logic              anyInvalid;
  setView_t          effView;
  recVec_t           effRec;
  logic              hit;
  logic [WAY_W-1:0]  hitWay;

  assign fillSet = refillAddr[PAGE_BITS +: SET_W];
  assign lookSet = lookupAddr[PAGE_BITS +: SET_W];
  assign lookTag = lookupAddr & PAGE_MASK;

  assign fillEntry = '{tag: refillAddr & PAGE_MASK, flags: refillFlags, payload: refillPayload};

  assign victim     = pickVictim(fillView, fillRecCur);
  assign fillRecNew = touchWay(fillRecCur, victim);
  assign sameSet    = refillValid && (fillSet == lookSet);

  always_comb begin
    anyInvalid = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (fillView[i].tag == INVALID_TAG) anyInvalid = 1'b1;
    end
  end

  // The lookup sees the set as the refill leaves it.
  always_comb begin
    effView = lookView;
    effRec  = lookRecCur;
    if (sameSet) begin
      effView[victim] = fillEntry;
      effRec          = fillRecNew;
    end
  end

  always_comb begin
    hit    = 1'b0;
    hitWay = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && effView[i].tag == lookTag) begin
        hit    = 1'b1;
        hitWay = WAY_W'(i);
      end
    end
  end

  always_comb begin
    strb             = '0;
    strb.invAll      = invalidateAll;
    strb.fillWe      = refillValid && !invalidateAll;
    strb.fillWay     = victim;
    strb.fillRec     = fillRecNew;
    strb.lookRecWe   = lookupValid && hit && !invalidateAll;
    strb.lookRec     = touchWay(effRec, hitWay);
    strb.respLoad    = lookupValid;
    strb.respHit     = lookupValid && hit && !invalidateAll;
    if (strb.respHit) begin
      strb.respWay     = hitWay;
      strb.respFlags   = effView[hitWay].flags;
      strb.respPayload = effView[hitWay].payload;
    end
  end

  // R6: an invalid way always wins when one exists
  a_r6_prefers_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && anyInvalid) |-> (fillView[victim].tag == INVALID_TAG));

  // R7: with a full set, an early victim must carry zero recency
  a_r7_zero_recency_victim: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !anyInvalid && victim != WAY_W'(WAYS-1))
      |-> (fillRecCur[victim*REC_W +: REC_W] == '0));
endmodule

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import tlbPkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [SET_W-1:0]  fillSet,
  input  logic [SET_W-1:0]  lookSet,
  input  wayEntry_t         fillEntry,
  output setView_t          fillView,
  output recVec_t           fillRecCur,
  output setView_t          lookView,
  output recVec_t           lookRecCur,
  output logic              respValid,
  output logic              respHit,
  output logic [WAY_W-1:0]  respWay,
  output logic [FLAG_W-1:0] respFlags,
  output logic [PAY_W-1:0]  respPayload,
  output logic              fillValid,
  output logic [WAY_W-1:0]  fillWay
);
  setView_t setArr [NUM_SETS];
  recVec_t  recArr [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : gSet
    setView_t viewQ;
    recVec_t  recQ;
    logic     fillHere;
    logic     lookHere;

    assign fillHere = strb.fillWe && (fillSet == SET_W'(g));
    assign lookHere = strb.lookRecWe && (lookSet == SET_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN || strb.invAll) begin
        viewQ <= {WAYS{EMPTY_WAY}};
        recQ  <= '0;
      end else begin
        if (fillHere) viewQ[strb.fillWay] <= fillEntry;
        if (lookHere)      recQ <= strb.lookRec;
        else if (fillHere) recQ <= strb.fillRec;
      end
    end

    assign setArr[g] = viewQ;
    assign recArr[g] = recQ;
  end

  assign fillView   = setArr[fillSet];
  assign fillRecCur = recArr[fillSet];
  assign lookView   = setArr[lookSet];
  assign lookRecCur = recArr[lookSet];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respWay     <= '0;
      respFlags   <= '0;
      respPayload <= '0;
      fillValid   <= 1'b0;
      fillWay     <= '0;
    end else begin
      respValid   <= strb.respLoad;
      respHit     <= strb.respHit;
      respWay     <= strb.respWay;
      respFlags   <= strb.respFlags;
      respPayload <= strb.respPayload;
      fillValid   <= strb.fillWe;
      fillWay     <= strb.fillWe ? strb.fillWay : '0;
    end
  end

  // R5: each pair is either both demoted (upper bit 0) or split 3/2
  logic r5PairOk;
  assign r5PairOk = (lookRecCur[1] == lookRecCur[3]) && (lookRecCur[5] == lookRecCur[7])
                 && (!lookRecCur[1] || (lookRecCur[0] != lookRecCur[2]))
                 && (!lookRecCur[5] || (lookRecCur[4] != lookRecCur[6]));

  a_r5_pair_shape: assert property (@(posedge clk) disable iff (!rstN) r5PairOk);

  // R8: set 0 stands empty right after a global invalidate
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.invAll |=> (setArr[0] == {WAYS{EMPTY_WAY}}) && (recArr[0] == '0));

  // R3: a miss reports all-zero fields
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respWay == '0 && respFlags == '0 && respPayload == '0));
endmodule

// File: rtl/tlb4way_hlru.sv
module tlb4way_hlru
  import tlbPkg::*;
#(
  parameter int NUM_SETS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [31:0]       lookupAddr,
  input  logic              refillValid,
  input  logic [31:0]       refillAddr,
  input  logic [1:0]        refillFlags,
  input  logic [31:0]       refillPayload,
  input  logic              invalidateAll,
  output logic              respValid,
  output logic              respHit,
  output logic [1:0]        respWay,
  output logic [1:0]        respFlags,
  output logic [31:0]       respPayload,
  output logic              fillValid,
  output logic [1:0]        fillWay
);
  localparam int SET_W = $clog2(NUM_SETS);

  ctrlStrobe_t      strb;
  logic [SET_W-1:0] fillSet;
  logic [SET_W-1:0] lookSet;
  wayEntry_t        fillEntry;
  setView_t         fillView;
  setView_t         lookView;
  recVec_t          fillRecCur;
  recVec_t          lookRecCur;

  tlb_hlru_ctrl #(.NUM_SETS(NUM_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .refillValid(refillValid), .refillAddr(refillAddr),
    .refillFlags(refillFlags), .refillPayload(refillPayload),
    .invalidateAll(invalidateAll),
    .fillView(fillView), .fillRecCur(fillRecCur),
    .lookView(lookView), .lookRecCur(lookRecCur),
    .fillSet(fillSet), .lookSet(lookSet), .fillEntry(fillEntry),
    .strb(strb)
  );

  tlb_way_store #(.NUM_SETS(NUM_SETS)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fillSet(fillSet), .lookSet(lookSet), .fillEntry(fillEntry),
    .fillView(fillView), .fillRecCur(fillRecCur),
    .lookView(lookView), .lookRecCur(lookRecCur),
    .respValid(respValid), .respHit(respHit), .respWay(respWay),
    .respFlags(respFlags), .respPayload(respPayload),
    .fillValid(fillValid), .fillWay(fillWay)
  );

  // R3: every lookup is answered exactly one cycle later
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);
  a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);
endmodule

// File: tb/tlb4way_hlru_tb.sv
module tlb4way_hlru_tb;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0, refillValid = 1'b0, invalidateAll = 1'b0;
  logic [31:0] lookupAddr = '0, refillAddr = '0, refillPayload = '0;
  logic [1:0]  refillFlags = '0;
  logic respValid, respHit, fillValid;
  logic [1:0] respWay, respFlags, fillWay;
  logic [31:0] respPayload;

  always #2 clk = ~clk;

  tlb4way_hlru #(.NUM_SETS(NS)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference
  logic [31:0] mTag [NS][4];
  logic [1:0]  mFlg [NS][4];
  logic [31:0] mPay [NS][4];
  int          mRec [NS][4];
  bit eRespValid, eRespHit, eFillValid;
  int eRespWay, eFillWay;
  logic [1:0] eRespFlags;
  logic [31:0] eRespPay;
  string lookReq, fillReq;

  task automatic modelClear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 4; w++) begin
        mTag[s][w] = 32'hFFFF_FFFF; mFlg[s][w] = 0; mPay[s][w] = 0; mRec[s][w] = 0;
      end
  endtask

  task automatic modelTouch(int s, int w);
    for (int k = 0; k < 4; k++) begin
      if (k / 2 == w / 2) mRec[s][k] = (k == w) ? 3 : 2;
      else mRec[s][k] = mRec[s][k] % 2;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelClear();
      armed = 0;
    end else begin
      int ls, fs, v;
      bit full;
      armed = 1;
      ls = (lookupAddr >> 12) % NS;
      fs = (refillAddr >> 12) % NS;
      eFillValid = 0; eFillWay = 0;
      eRespValid = lookupValid; eRespHit = 0; eRespWay = 0; eRespFlags = 0; eRespPay = 0;
      lookReq = (refillValid && ls == fs) ? "R9" : "R4";
      fillReq = "R6";
      if (invalidateAll) begin
        modelClear();
        lookReq = "R8"; fillReq = "R8";
      end else begin
        if (refillValid) begin
          v = -1;
          for (int w = 0; w < 4; w++) if (v < 0 && mTag[fs][w] == 32'hFFFF_FFFF) v = w;
          full = (v < 0);
          for (int w = 0; w < 3; w++) if (v < 0 && mRec[fs][w] == 0) v = w;
          if (v < 0) v = 3;
          if (full) fillReq = "R7";
          mTag[fs][v] = refillAddr & 32'hFFFF_F000;
          mFlg[fs][v] = refillFlags; mPay[fs][v] = refillPayload;
          modelTouch(fs, v);
          eFillValid = 1; eFillWay = v;
        end
        if (lookupValid) begin
          for (int w = 0; w < 4; w++)
            if (!eRespHit && mTag[ls][w] == (lookupAddr & 32'hFFFF_F000)) begin
              eRespHit = 1; eRespWay = w; eRespFlags = mFlg[ls][w]; eRespPay = mPay[ls][w];
            end
          if (eRespHit) modelTouch(ls, eRespWay);
          else if (lookReq == "R4") lookReq = "R3";
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && rstN) begin
      chk(lookReq, "respValid", 64'(respValid), 64'(eRespValid));
      if (eRespValid) begin
        chk(lookReq, "respHit", 64'(respHit), 64'(eRespHit));
        chk(lookReq, "respWay", 64'(respWay), 64'(eRespWay));
        chk(lookReq, "respFlags", 64'(respFlags), 64'(eRespFlags));
        chk(lookReq, "respPayload", 64'(respPayload), 64'(eRespPay));
      end
      chk("R10", "fillValid", 64'(fillValid), 64'(eFillValid));
      chk(fillReq, "fillWay", 64'(fillWay), 64'(eFillWay));
    end
  end

  function automatic logic [31:0] mkAddr(int hi, int s, int off);
    return (32'(hi) << 16) | (32'(s) << 12) | 32'(off & 12'hFFF);
  endfunction

  task automatic step(bit lv, logic [31:0] la, bit rv, logic [31:0] ra, bit inv);
    @(negedge clk);
    lookupValid = lv; lookupAddr = la;
    refillValid = rv; refillAddr = ra;
    refillFlags = 2'(ra[17:16]); refillPayload = ra ^ 32'h5A5A_0000;
    invalidateAll = inv;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "respValid in reset", 64'(respValid), 0);
        chk("R1", "fillValid in reset", 64'(fillValid), 0);
        rstN = 1'b1;
        phase = "R1"; step(1, mkAddr(1, 3, 0), 0, 0, 0);
        phase = "R6";
        for (int i = 0; i < 4; i++) step(0, 0, 1, mkAddr(i + 1, 3, 7), 0);
        phase = "R2";
        for (int i = 0; i < 4; i++) step(1, mkAddr(i + 1, 3, 12'h123 * (i + 1)), 0, 0, 0);
        phase = "R5";
        step(1, mkAddr(3, 3, 0), 0, 0, 0);
        step(0, 0, 1, mkAddr(9, 3, 0), 0);
        step(0, 0, 1, mkAddr(10, 3, 0), 0);
        step(0, 0, 1, mkAddr(11, 3, 0), 0);
        phase = "R9";
        step(1, mkAddr(12, 5, 4), 1, mkAddr(12, 5, 0), 0);
        step(1, mkAddr(11, 3, 4), 1, mkAddr(13, 3, 0), 0);
        phase = "R8";
        step(1, mkAddr(12, 5, 0), 1, mkAddr(14, 5, 0), 1);
        step(1, mkAddr(12, 5, 0), 0, 0, 0);
        phase = "R10";
        for (int i = 0; i < 3000; i++) begin
          int r;
          r = int'($urandom % 100);
          step($urandom % 10 < 6, mkAddr(int'($urandom % 6), int'($urandom % 4), int'($urandom)),
               $urandom % 10 < 3, mkAddr(int'($urandom % 6), int'($urandom % 4), 0), r == 0);
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule